// File: doc/BRIEF.md
# Digital I/O Register Window Decoder

This block decodes a sixteen-byte register window on a small byte bus and holds the state of a digital I/O card. It owns the latches for twenty-four switched outputs. It owns a latch and a direction control for an eight-line bidirectional logic port, and a small control register that also selects the input filters. It returns the live levels of twenty-four isolated inputs and of the eight logic pins.

The change-of-state detector sits outside this block and connects through dedicated ports:

- Reads of its status bytes and of its enable byte are forwarded to the bus.
- Writes to the clear bytes and to the enable byte appear as one-cycle strobes, together with the write data.
- A write of any value to the top address is a board-level soft reset. It restores the control register, switches every output off and raises a strobe so the detector can drop its status.

Read data is combinational from the address while the read strobe is high, and is zero otherwise. A write takes effect on the rising clock edge at which the write strobe is high. One address can mean different things on read and on write.

Top module: `dio_regbank`

## Requirements
- R1: While `rst` is high at a clock edge, the edge leaves `out_lines` at 0, the port latch at 0 and the control byte at 0x01, so `ttl_pin_oe`, `filt_en_lo` and `filt_en_hi` are 0.
- R2: A write to offset 0, 1 or 2 loads bits 7:0, 15:8 or 23:16 of `out_lines`, where a 1 turns the line on. A read of the same offset returns that byte.
- R3: A write to offset 3 loads the port latch, which drives `ttl_pin_out` and reads back at offset 3. `ttl_pin_oe` is 1 only when control bit 0 (buffer enable) and control bit 1 (output mode) are both 1.
- R4: Reads of offsets 4, 5 and 6 return the live `iso_in` bits 7:0, 15:8 and 23:16. Writes to offsets 4, 5, 6, 7 and D change neither `out_lines`, nor the port latch, nor the control byte.
- R5: A read of offset 7 returns the live `ttl_pin_in` levels.
- R6: A write to offset C stores data bits 3:0 in the control byte. A read returns the stored bits with bits 7:4 as 0. `filt_en_lo` follows control bit 2 (inputs 0-11) and `filt_en_hi` follows control bit 3 (inputs 12-23).
- R7: A write of any data to offset F sets the control byte to 0x01 and `out_lines` to 0 at that edge, and holds `cos_sw_reset` high during the write cycle. The port latch keeps its value.
- R8: Reads of offsets 8 to B return bytes 0 to 3 of `cos_status`, with byte 0 in bits 7:0. During a write to offset 8+k, `cos_clr_byte` is one-hot with bit k set and `cos_wdata` equals `bus_wdata`. At all other times `cos_clr_byte` is 0.
- R9: A read of offset E returns `cos_enable`, and `cos_en_we` is high during a write to offset E. A read of offset F returns `irq_level` in bit 0, with bits 7:1 as 0.
- R10: A read of reserved offset D returns 0, and `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| out_lines | output | 24 | Switched output commands, 1 = on |
| iso_in | input | 24 | Isolated input levels, 1 = energised |
| ttl_pin_in | input | 8 | Sensed logic-port pin levels |
| ttl_pin_out | output | 8 | Logic-port drive values |
| ttl_pin_oe | output | 1 | Logic-port driver enable |
| filt_en_lo | output | 1 | Filter select for inputs 0-11 |
| filt_en_hi | output | 1 | Filter select for inputs 12-23 |
| cos_status | input | 32 | Change-of-state status from the detector |
| cos_enable | input | 8 | Enable byte held by the detector |
| irq_level | input | 1 | Interrupt level from the detector |
| cos_clr_byte | output | 4 | Per-byte clear strobes to the detector |
| cos_en_we | output | 1 | Enable-byte write strobe |
| cos_wdata | output | 8 | Data for clear and enable writes |
| cos_sw_reset | output | 1 | Soft-reset strobe to the detector |

## Verification
The assertions assume that `bus_wr` is a clean one-cycle pulse with a stable address and data around the sampling edge. They also assume that `bus_rd` and `bus_wr` are never high together. The assertion on a rising driver enable assumes that nothing but a bus write or a reset moves the control byte. The bench drives every bus signal on the falling edge and raises one strobe at a time. Where a read sits next to a write, a full idle cycle separates them, so each check of a combinational read or strobe is taken in the middle of the low phase, before the next rising edge.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int BYTE_W        = 8;
    localparam int ADDR_W        = 4;
    localparam int OUT_BYTES     = 3;
    localparam int IN_BYTES      = 3;
    localparam int COS_BYTES     = 4;
    localparam int OUT_W         = OUT_BYTES * BYTE_W;
    localparam int IN_W          = IN_BYTES * BYTE_W;
    localparam int COS_W         = COS_BYTES * BYTE_W;

    typedef logic [ADDR_W-1:0] ofs_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam ofs_t OFS_OUT_BASE  = 4'h0;
    localparam ofs_t OFS_TTL_LATCH = 4'h3;
    localparam ofs_t OFS_IN_BASE   = 4'h4;
    localparam ofs_t OFS_TTL_PINS  = 4'h7;
    localparam ofs_t OFS_COS_BASE  = 4'h8;
    localparam ofs_t OFS_CTRL      = 4'hC;
    localparam ofs_t OFS_RSVD      = 4'hD;
    localparam ofs_t OFS_COS_EN    = 4'hE;
    localparam ofs_t OFS_IRQ_RST   = 4'hF;

    // Control byte, LSB first: buffer enable, output mode, filter lo, filter hi.
    typedef struct packed {
        logic filt_hi;
        logic filt_lo;
        logic ttl_out_mode;
        logic ttl_buf_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic ctrl_t ctrl_default();
        ctrl_t c;
        c = '0;
        c.ttl_buf_en = 1'b1;
        return c;
    endfunction

    function automatic byte_t ctrl_to_byte(ctrl_t c);
        return {{(BYTE_W-CTRL_W){1'b0}}, c};
    endfunction

    function automatic logic ofs_in_span(ofs_t a, ofs_t base, int count);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + count);
    endfunction

endpackage

// File: rtl/dio_out_bank.sv
module dio_out_bank
    import dio_pkg::*;
#(
    parameter int NUM_BYTES = OUT_BYTES,
    parameter int LANE_W    = BYTE_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_BYTES-1:0]          byte_we,
    input  logic                          clear,
    input  logic [LANE_W-1:0]             wdata,
    output logic [NUM_BYTES*LANE_W-1:0]   q
);

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                lane_q <= '0;
            end else if (byte_we[i]) begin
                lane_q <= wdata;
            end
        end

        assign q[i*LANE_W +: LANE_W] = lane_q;

        // R2
        lane_load_chk: assert property (@(posedge clk) disable iff (rst)
            (byte_we[i] && !clear) |=> (lane_q == $past(wdata)));
    end

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|byte_we) && !clear) |=> $stable(q));

    // R7
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (q == '0));

endmodule

// File: rtl/dio_ctrl_reg.sv
module dio_ctrl_reg
    import dio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              restore,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst || restore) begin
            ctrl_q <= ctrl_default();
        end else if (we) begin
            ctrl_q <= ctrl_t'(wdata);
        end
    end

    assign ctrl = ctrl_q;

    // R6
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !restore) |=> (ctrl_q == ctrl_t'($past(wdata))));

    // R7
    ctrl_restore_chk: assert property (@(posedge clk) disable iff (rst)
        restore |=> (ctrl_q == ctrl_default()));

    // R4
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!we && !restore) |=> $stable(ctrl_q));

endmodule

// File: rtl/dio_ttl_port.sv
module dio_ttl_port
    import dio_pkg::*;
#(
    parameter int PORT_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PORT_W-1:0] wdata,
    input  ctrl_t             ctrl,
    output logic [PORT_W-1:0] latch,
    output logic              drive_en
);

    logic [PORT_W-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (we) begin
            latch_q <= wdata;
        end
    end

    assign latch    = latch_q;
    assign drive_en = ctrl.ttl_buf_en & ctrl.ttl_out_mode;

    // R3
    ttl_load_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (latch_q == $past(wdata)));

    // R7
    ttl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(latch_q));

endmodule

// File: rtl/dio_read_mux.sv
module dio_read_mux
    import dio_pkg::*;
(
    input  logic             rd,
    input  ofs_t             addr,
    input  logic [OUT_W-1:0] out_q,
    input  byte_t            ttl_latch,
    input  logic [IN_W-1:0]  iso_in,
    input  byte_t            ttl_pins,
    input  logic [COS_W-1:0] cos_status,
    input  byte_t            ctrl_byte,
    input  byte_t            cos_enable,
    input  logic             irq_level,
    output byte_t            rdata
);

    byte_t sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < OUT_BYTES; i++) begin
            if (addr == ofs_t'(int'(OFS_OUT_BASE) + i)) sel = out_q[i*BYTE_W +: BYTE_W];
        end
        for (int i = 0; i < IN_BYTES; i++) begin
            if (addr == ofs_t'(int'(OFS_IN_BASE) + i)) sel = iso_in[i*BYTE_W +: BYTE_W];
        end
        for (int i = 0; i < COS_BYTES; i++) begin
            if (addr == ofs_t'(int'(OFS_COS_BASE) + i)) sel = cos_status[i*BYTE_W +: BYTE_W];
        end
        case (addr)
            OFS_TTL_LATCH: sel = ttl_latch;
            OFS_TTL_PINS:  sel = ttl_pins;
            OFS_CTRL:      sel = ctrl_byte;
            OFS_COS_EN:    sel = cos_enable;
            OFS_IRQ_RST:   sel = {{(BYTE_W-1){1'b0}}, irq_level};
            default:       ;
        endcase
    end

    assign rdata = rd ? sel : '0;

endmodule

// File: rtl/dio_regbank.sv
module dio_regbank
    import dio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic [OUT_W-1:0]    out_lines,
    input  logic [IN_W-1:0]     iso_in,
    input  logic [BYTE_W-1:0]   ttl_pin_in,
    output logic [BYTE_W-1:0]   ttl_pin_out,
    output logic                ttl_pin_oe,
    output logic                filt_en_lo,
    output logic                filt_en_hi,
    input  logic [COS_W-1:0]    cos_status,
    input  logic [BYTE_W-1:0]   cos_enable,
    input  logic                irq_level,
    output logic [COS_BYTES-1:0] cos_clr_byte,
    output logic                cos_en_we,
    output logic [BYTE_W-1:0]   cos_wdata,
    output logic                cos_sw_reset
);

    logic [OUT_BYTES-1:0] out_we;
    logic                 ttl_we;
    logic                 ctrl_we;
    logic                 soft_rst;
    ctrl_t                ctrl;
    byte_t                ttl_latch;

    for (genvar i = 0; i < OUT_BYTES; i++) begin : g_out_dec
        assign out_we[i] = bus_wr && (bus_addr == ofs_t'(int'(OFS_OUT_BASE) + i));
    end

    for (genvar k = 0; k < COS_BYTES; k++) begin : g_cos_dec
        assign cos_clr_byte[k] = bus_wr && (bus_addr == ofs_t'(int'(OFS_COS_BASE) + k));
    end

    assign ttl_we       = bus_wr && (bus_addr == OFS_TTL_LATCH);
    assign ctrl_we      = bus_wr && (bus_addr == OFS_CTRL);
    assign soft_rst     = bus_wr && (bus_addr == OFS_IRQ_RST);
    assign cos_en_we    = bus_wr && (bus_addr == OFS_COS_EN);
    assign cos_sw_reset = soft_rst;
    assign cos_wdata    = bus_wdata;

    dio_out_bank #(
        .NUM_BYTES (OUT_BYTES),
        .LANE_W    (BYTE_W)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .byte_we (out_we),
        .clear   (soft_rst),
        .wdata   (bus_wdata),
        .q       (out_lines)
    );

    dio_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we      (ctrl_we),
        .restore (soft_rst),
        .wdata   (bus_wdata[CTRL_W-1:0]),
        .ctrl    (ctrl)
    );

    dio_ttl_port #(
        .PORT_W (BYTE_W)
    ) u_ttl (
        .clk      (clk),
        .rst      (rst),
        .we       (ttl_we),
        .wdata    (bus_wdata),
        .ctrl     (ctrl),
        .latch    (ttl_latch),
        .drive_en (ttl_pin_oe)
    );

    assign ttl_pin_out = ttl_latch;
    assign filt_en_lo  = ctrl.filt_lo;
    assign filt_en_hi  = ctrl.filt_hi;

    dio_read_mux u_rmux (
        .rd         (bus_rd),
        .addr       (bus_addr),
        .out_q      (out_lines),
        .ttl_latch  (ttl_latch),
        .iso_in     (iso_in),
        .ttl_pins   (ttl_pin_in),
        .cos_status (cos_status),
        .ctrl_byte  (ctrl_to_byte(ctrl)),
        .cos_enable (cos_enable),
        .irq_level  (irq_level),
        .rdata      (bus_rdata)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (out_lines == '0 && ttl_pin_out == '0 && !ttl_pin_oe && !filt_en_lo && !filt_en_hi));

    // R3
    oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ttl_pin_oe) |-> $past(bus_wr && bus_addr == OFS_CTRL));

    // R8
    clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cos_clr_byte));

    // R8
    clr_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (cos_clr_byte != '0) |-> bus_wr);

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_RSVD) |-> (bus_rdata == '0));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/dio_regbank_test.sv
module dio_regbank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] out_lines;
    logic [23:0] iso_in = '0;
    logic [7:0]  ttl_pin_in = '0;
    logic [7:0]  ttl_pin_out;
    logic        ttl_pin_oe;
    logic        filt_en_lo;
    logic        filt_en_hi;
    logic [31:0] cos_status = '0;
    logic [7:0]  cos_enable = '0;
    logic        irq_level = 1'b0;
    logic [3:0]  cos_clr_byte;
    logic        cos_en_we;
    logic [7:0]  cos_wdata;
    logic        cos_sw_reset;

    always #5 clk = ~clk;

    dio_regbank uut (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .out_lines    (out_lines),
        .iso_in       (iso_in),
        .ttl_pin_in   (ttl_pin_in),
        .ttl_pin_out  (ttl_pin_out),
        .ttl_pin_oe   (ttl_pin_oe),
        .filt_en_lo   (filt_en_lo),
        .filt_en_hi   (filt_en_hi),
        .cos_status   (cos_status),
        .cos_enable   (cos_enable),
        .irq_level    (irq_level),
        .cos_clr_byte (cos_clr_byte),
        .cos_en_we    (cos_en_we),
        .cos_wdata    (cos_wdata),
        .cos_sw_reset (cos_sw_reset)
    );

    // Observed signal selectors.
    localparam int K_RDATA = 0, K_OUT = 1, K_TTLO = 2, K_OE = 3, K_FILT = 4,
                   K_CLR = 5, K_ENWE = 6, K_SWRST = 7, K_CWD = 8;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  item_ev;
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    function automatic logic [31:0] observe(int kind);
        case (kind)
            K_RDATA: return {24'd0, bus_rdata};
            K_OUT:   return {8'd0, out_lines};
            K_TTLO:  return {24'd0, ttl_pin_out};
            K_OE:    return {31'd0, ttl_pin_oe};
            K_FILT:  return {30'd0, filt_en_hi, filt_en_lo};
            K_CLR:   return {28'd0, cos_clr_byte};
            K_ENWE:  return {31'd0, cos_en_we};
            K_SWRST: return {31'd0, cos_sw_reset};
            K_CWD:   return {24'd0, cos_wdata};
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    // Monitor: pops expected items and compares them with the live outputs.
    initial begin
        forever begin
            @(item_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = observe(it.kind);
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_exp(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        q.push_back(it);
        -> item_ev;
        #1;
    endtask

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Check a combinational strobe during a write cycle, then let it land.
    task automatic write_strobe(logic [3:0] a, logic [7:0] d, int kind, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #2;
        push_exp(kind, exp, tag);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(logic [3:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a; bus_rd = 1'b1;
        #2;
        push_exp(K_RDATA, {24'd0, exp}, tag);
    endtask

    task automatic port_chk(int kind, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b0;
        #2;
        push_exp(kind, exp, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        port_chk(K_OUT, 32'h0, "R1 outputs off");
        port_chk(K_OE, 32'h0, "R1 driver off");
        port_chk(K_FILT, 32'h0, "R1 filters off");
        read_chk(4'hC, 8'h01, "R1 control default");
        read_chk(4'h3, 8'h00, "R1 port latch zero");

        // R2 output bytes
        bus_write(4'h0, 8'hA5);
        bus_write(4'h1, 8'h3C);
        bus_write(4'h2, 8'h81);
        port_chk(K_OUT, 32'h0081_3CA5, "R2 output lines");
        read_chk(4'h0, 8'hA5, "R2 readback byte0");
        read_chk(4'h1, 8'h3C, "R2 readback byte1");
        read_chk(4'h2, 8'h81, "R2 readback byte2");

        // R3 port latch and driver enable
        bus_write(4'h3, 8'h5A);
        read_chk(4'h3, 8'h5A, "R3 latch readback");
        port_chk(K_TTLO, 32'h5A, "R3 pin drive value");
        port_chk(K_OE, 32'h0, "R3 oe off with buffer only");
        bus_write(4'hC, 8'h03);
        port_chk(K_OE, 32'h1, "R3 oe on with both bits");
        bus_write(4'hC, 8'h02);
        port_chk(K_OE, 32'h0, "R3 oe off with mode only");

        // R4 live isolated inputs
        iso_in = 24'hC3_0F_96;
        read_chk(4'h4, 8'h96, "R4 input byte0");
        read_chk(4'h5, 8'h0F, "R4 input byte1");
        read_chk(4'h6, 8'hC3, "R4 input byte2");
        iso_in = 24'h11_22_33;
        read_chk(4'h5, 8'h22, "R4 input byte1 live");

        // R4 writes to read-only and reserved offsets have no effect
        bus_write(4'h4, 8'hFF);
        bus_write(4'h5, 8'hFF);
        bus_write(4'h6, 8'hFF);
        bus_write(4'h7, 8'hFF);
        bus_write(4'hD, 8'hFF);
        port_chk(K_OUT, 32'h0081_3CA5, "R4 outputs untouched");
        read_chk(4'h3, 8'h5A, "R4 port latch untouched");
        read_chk(4'hC, 8'h02, "R4 control untouched");

        // R5 pin levels
        ttl_pin_in = 8'h77;
        read_chk(4'h7, 8'h77, "R5 pin levels");
        ttl_pin_in = 8'h08;
        read_chk(4'h7, 8'h08, "R5 pin levels live");

        // R6 control register
        bus_write(4'hC, 8'hFF);
        read_chk(4'hC, 8'h0F, "R6 upper bits read zero");
        port_chk(K_FILT, 32'h3, "R6 both filters");
        bus_write(4'hC, 8'h04);
        port_chk(K_FILT, 32'h1, "R6 low filter only");
        bus_write(4'hC, 8'h08);
        port_chk(K_FILT, 32'h2, "R6 high filter only");

        // R8 change-of-state pass-through
        cos_status = 32'hDD_CC_BB_AA;
        read_chk(4'h8, 8'hAA, "R8 status byte0");
        read_chk(4'h9, 8'hBB, "R8 status byte1");
        read_chk(4'hA, 8'hCC, "R8 status byte2");
        read_chk(4'hB, 8'hDD, "R8 status byte3");
        write_strobe(4'h9, 8'h42, K_CLR, 32'h2, "R8 clear strobe byte1");
        write_strobe(4'hB, 8'h9E, K_CWD, 32'h9E, "R8 clear data");
        write_strobe(4'hB, 8'h01, K_CLR, 32'h8, "R8 clear strobe byte3");
        port_chk(K_CLR, 32'h0, "R8 no strobe when idle");

        // R9 enable byte and interrupt level
        cos_enable = 8'h5E;
        read_chk(4'hE, 8'h5E, "R9 enable readback");
        write_strobe(4'hE, 8'h33, K_ENWE, 32'h1, "R9 enable write strobe");
        irq_level = 1'b1;
        read_chk(4'hF, 8'h01, "R9 irq level high");
        irq_level = 1'b0;
        read_chk(4'hF, 8'h00, "R9 irq level low");

        // R10 reserved and idle reads
        read_chk(4'hD, 8'h00, "R10 reserved reads zero");
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 4'h0;
        #2;
        push_exp(K_RDATA, 32'h0, "R10 idle rdata zero");

        // R7 soft reset
        bus_write(4'hC, 8'h0F);
        write_strobe(4'hF, 8'h00, K_SWRST, 32'h1, "R7 soft reset strobe");
        port_chk(K_OUT, 32'h0, "R7 outputs cleared");
        read_chk(4'hC, 8'h01, "R7 control restored");
        read_chk(4'h3, 8'h5A, "R7 port latch kept");
        port_chk(K_SWRST, 32'h0, "R7 strobe drops");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule